// File: doc/BRIEF.md
# Mirrored Barrel Shifter

This block shifts a 32-bit word left logically or right arithmetically by a 5-bit amount. It has no clock and no state: the result follows the inputs through combinational logic. An operation code selects the direction. A datapath uses it as the shift unit next to its adder and logic units.

There is a single left-shifting network. It has one mux stage for each bit of the amount, and the stages move the word by 1, 2, 4, 8 and 16 places in that order. A left shift feeds the word straight into the network, and zeros enter at the bottom. A right shift first mirrors the word bit by bit and sends it through the same network. The network then fills with the input's sign bit instead of zero, and the output is mirrored back. The combined effect is an arithmetic right shift.

Top module: `barrel_shift_unit`

## Requirements
- R1: With operation code 5'b00100, `result` equals `data_in` shifted left by `shamt` places, and the low `shamt` bits of `result` are zero.
- R2: With operation code 5'b00101, `result` equals `data_in`, read as a signed two's-complement number, shifted right arithmetically by `shamt` places.
- R3: When `shamt` is 0, `result` equals `data_in` under every operation code.
- R4: Only code 5'b00101 selects the right shift. Every other code, including 5'b00100, 5'b00000 and 5'b11111, gives the left-shift result.
- R5: In a right shift, the top `shamt` bits of `result` all equal bit 31 of the unmirrored `data_in`.
- R6: In a right shift, bit 31 of `result` equals bit 31 of `data_in`. Read as unsigned, `result` is no greater than `data_in` when that bit is 0 and no less than `data_in` when it is 1.
- R7: A `shamt` value with only bit k set moves the word by exactly 2^k places in either direction. Bit 0 stands for 1 place and bit 4 for 16 places.
- R8: `result` is combinational and settles within the same cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word to be shifted |
| shamt | input | 5 | Shift distance, 0 to 31 |
| opcode | input | 5 | Operation code; 5'b00101 selects the arithmetic right shift, any other code the left shift |
| result | output | 32 | Shifted word |

## Verification
The bench builds the block with its default width of 32, so the amount is 5 bits wide. Every distance from 0 to 31 is driven, and each distance with a single bit set exercises exactly one mux stage on its own. The data words include zero, all ones, alternating patterns and the two sign-boundary values, and each is run under both shift codes and two unrelated codes. This covers sign fill on negative inputs, zero fill, the pass-through at distance 0, and the rule that unrelated codes fall back to the left shift.

// File: rtl/shift_pkg.sv
package shift_pkg;

  localparam int OPC_W = 5;
  localparam logic [OPC_W-1:0] OPC_SHL = 5'b00100;
  localparam logic [OPC_W-1:0] OPC_SAR = 5'b00101;

  // Mirror a vector end for end: bit i moves to bit (n-1-i).
  function automatic logic [63:0] mirror64(input logic [63:0] v, input int n);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[n-1-i] = v[i];
    return r;
  endfunction

  // Mask with the low n bits set.
  function automatic logic [63:0] low_ones(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/word_mirror.sv
module word_mirror #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign dst[WIDTH-1-i] = src[i];
    end
  endgenerate
endmodule

// File: rtl/lshift_core.sv
module lshift_core #(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [0:AMT_W];

  assign stage[0] = din;

  generate
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      logic [WIDTH-1:0] moved;
      assign moved        = {stage[k][WIDTH-1-STEP:0], {STEP{fill}}};
      assign stage[k+1]   = amt[k] ? moved : stage[k];
    end
  endgenerate

  assign dout = stage[AMT_W];
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] shamt,
  input  logic [OPC_W-1:0] opcode,
  output logic [WIDTH-1:0] result
);
  logic             is_sar;
  logic             sign_bit;
  logic             fill_bit;
  logic [WIDTH-1:0] core_in;
  logic [WIDTH-1:0] core_out;
  logic [WIDTH-1:0] mirrored_in;
  logic [WIDTH-1:0] mirrored_out;

  assign is_sar   = (opcode == OPC_SAR);
  assign sign_bit = data_in[WIDTH-1];
  assign fill_bit = is_sar & sign_bit;

  word_mirror #(.WIDTH(WIDTH)) u_mirror_in (
    .src (data_in),
    .dst (mirrored_in)
  );

  assign core_in = is_sar ? mirrored_in : data_in;

  lshift_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_core (
    .din  (core_in),
    .amt  (shamt),
    .fill (fill_bit),
    .dout (core_out)
  );

  word_mirror #(.WIDTH(WIDTH)) u_mirror_out (
    .src (core_out),
    .dst (mirrored_out)
  );

  assign result = is_sar ? mirrored_out : core_out;

  always_comb begin
    // R3
    zero_pass_chk: assert (shamt != '0 || result == data_in);
    // R1
    shl_lsb_chk: assert (is_sar || shamt == '0 || result[0] == 1'b0);
    // R6
    sar_sign_chk: assert (!is_sar || result[WIDTH-1] == data_in[WIDTH-1]);
    // R6
    sar_order_chk: assert (!is_sar ||
                           (data_in[WIDTH-1] ? (result >= data_in) : (result <= data_in)));
  end
endmodule

// File: tb/tb_barrel_shift_unit.sv
module tb_barrel_shift_unit;
  import shift_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int A = 5;

  logic         clk = 1'b0;
  logic [W-1:0] data_in;
  logic [A-1:0] shamt;
  logic [4:0]   opcode;
  logic [W-1:0] result;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shift_unit dut (
    .data_in (data_in),
    .shamt   (shamt),
    .opcode  (opcode),
    .result  (result)
  );

  // Behavioural reference
  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int s,
                                         input logic [4:0] op);
    logic signed [W-1:0] sd;
    sd = d;
    if (op == 5'b00101) return W'(sd >>> s);
    return d << s;
  endfunction

  task automatic check(input logic [W-1:0] exp, input string tag);
    compared++;
    if (result !== exp) begin
      mismatched++;
      $display("FAIL %s: data=%h shamt=%0d op=%b got=%h exp=%h",
               tag, data_in, shamt, opcode, result, exp);
    end
  endtask

  logic [W-1:0] words [0:7];
  logic [4:0]   ops   [0:3];

  initial begin
    words[0] = 32'h0000_0000; words[1] = 32'hFFFF_FFFF;
    words[2] = 32'h8000_0000; words[3] = 32'h7FFF_FFFF;
    words[4] = 32'hA5A5_5A5A; words[5] = 32'h1234_5678;
    words[6] = 32'hDEAD_BEEF; words[7] = 32'h0000_0001;
    ops[0] = OPC_SHL; ops[1] = OPC_SAR; ops[2] = 5'b00000; ops[3] = 5'b11111;
    data_in = '0; shamt = '0; opcode = OPC_SHL;

    // R8: sample after inputs settle, same cycle
    @(negedge clk);
    check(32'h0, "R8 initial");

    for (int w = 0; w < 8; w++) begin
      for (int o = 0; o < 4; o++) begin
        for (int s = 0; s < 32; s++) begin
          @(posedge clk);
          data_in = words[w]; opcode = ops[o]; shamt = A'(s);
          @(negedge clk);
          if (s == 0)
            check(words[w], "R3 zero distance");
          else if ($countones(s) == 1)
            check(model(words[w], s, ops[o]), "R7 single stage");
          else if (ops[o] == OPC_SAR)
            check(model(words[w], s, ops[o]), "R2 arithmetic right");
          else if (ops[o] == OPC_SHL)
            check(model(words[w], s, ops[o]), "R1 left shift");
          else
            check(model(words[w], s, ops[o]), "R4 other code");
          if (ops[o] == OPC_SAR) begin
            // R5: top s bits copy input sign
            compared++;
            if ((result & ~(W'(low_ones(W - s)))) !==
                (words[w][W-1] ? ~(W'(low_ones(W - s))) : W'(0))) begin
              mismatched++;
              $display("FAIL R5 sign fill: got=%h data=%h s=%0d", result, words[w], s);
            end
          end
        end
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule